// File: doc/BRIEF.md
# Cross-Clock Single-Word Mailbox

This block carries one data word at a time from a producer running on one clock to a consumer running on a second, unrelated clock. The producer raises a write strobe for one cycle with a word on its data input. If the mailbox is empty, the word is latched into a holding register and the producer sees the mailbox as full until the consumer has taken the word.

On the consumer side, an exists flag shows that a word is waiting on the data output. A read strobe, given while exists is high, takes the word. The flag then clears on the following consumer edge.

The crossing does not sample the write strobe in the consumer domain, so a short strobe is never lost. A write flips a request toggle bit, and a read flips an acknowledge toggle bit. Each toggle crosses into the other domain through a chain of synchronizer flops. The delivery of a one-cycle strobe therefore does not depend on which clock is faster.

Top module: `xclk_mailbox`

## Requirements
- R1: The data path is DATA_W bits wide (default 16). While exists is high, rdData equals the word of the last accepted write.
- R2: A write is accepted when wrEn is high and full is low at a producer clock edge. From the next producer cycle on, full reads high.
- R3: An accepted write, even a strobe only one producer cycle long, raises exists within SYNC_STAGES+1 consumer clock edges, whatever the ratio between the two clocks.
- R4: A read (rdEn high while exists is high at a consumer edge) drops exists in the next consumer cycle. Full then clears once the acknowledge has crossed back, so the producer can write again.
- R5: A write attempted while full is high is ignored. The holding register and the word that is delivered stay unchanged, and no extra word is delivered.
- R6: rdEn while exists is low has no effect. Exists stays low and full stays low.
- R7: mbRst is an active-high asynchronous reset. It forces full and exists low at once in both domains, and the mailbox leaves reset empty.
- R8: Every accepted word is read exactly once and in write order, with the consumer clock both slower and faster than the producer clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prodClk | input | 1 | Producer clock |
| consClk | input | 1 | Consumer clock |
| mbRst | input | 1 | Asynchronous reset, active high, both domains |
| wrEn | input | 1 | Producer write strobe |
| wrData | input | DATA_W | Producer data word |
| full | output | 1 | Mailbox occupied; writes are ignored while high (producer clock) |
| rdEn | input | 1 | Consumer read strobe |
| exists | output | 1 | A word is waiting on rdData (consumer clock) |
| rdData | output | DATA_W | Word held in the mailbox |

## Verification
The hardest case to reach is a one-cycle write strobe from a fast producer that falls entirely between two edges of a much slower consumer clock. A second hard case is a write attempted in the same producer cycle in which the acknowledge is about to return.

The bench reaches both cases by sweeping the consumer clock across three ratios: slower, faster and equal to the producer clock. The producer writes on the first free producer cycle, and it fires rejected writes with corrupted data while full is high. The consumer mixes reads with stray read strobes while the mailbox is empty.

// File: rtl/xclk_mailbox_pkg.sv
package xclk_mailbox_pkg;

  // Strobes from control to datapath, producer clock domain.
  typedef struct packed {
    logic capture;  // latch wrData into the holding register
  } mbStrobes_t;

endpackage

// File: rtl/xclk_mailbox_sync.sv
module xclk_mailbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dIn,
  output logic dOut
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] pipe;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= dIn;
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign dOut = pipe[LAST];

endmodule

// File: rtl/xclk_mailbox_ctrl.sv
module xclk_mailbox_ctrl
  import xclk_mailbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       prodClk,
  input  logic       consClk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       rdEn,
  output logic       full,
  output logic       exists,
  output mbStrobes_t strobes
);
  logic reqTog;
  logic ackTog;
  logic reqSync;
  logic ackSync;
  logic accept;
  logic consume;

  // Producer domain: the request toggle flips on every accepted write.
  assign full   = reqTog ^ ackSync;
  assign accept = wrEn & ~full;

  always_ff @(posedge prodClk or posedge rst) begin
    if (rst) reqTog <= 1'b0;
    else if (accept) reqTog <= ~reqTog;
  end

  assign strobes.capture = accept;

  xclk_mailbox_sync #(.STAGES(SYNC_STAGES)) reqSync_i (
    .clk (consClk),
    .rst (rst),
    .dIn (reqTog),
    .dOut(reqSync)
  );

  // Consumer domain: the acknowledge toggle flips on every read.
  assign exists  = reqSync ^ ackTog;
  assign consume = rdEn & exists;

  always_ff @(posedge consClk or posedge rst) begin
    if (rst) ackTog <= 1'b0;
    else if (consume) ackTog <= ~ackTog;
  end

  xclk_mailbox_sync #(.STAGES(SYNC_STAGES)) ackSync_i (
    .clk (prodClk),
    .rst (rst),
    .dIn (ackTog),
    .dOut(ackSync)
  );

  // R2: an accepted write makes the mailbox full in the next cycle.
  p_full_set_r2: assert property (@(posedge prodClk) disable iff (rst)
    (wrEn && !full) |=> full);

  // R4: a read empties the consumer side in the next cycle.
  p_exists_drop_r4: assert property (@(posedge consClk) disable iff (rst)
    (rdEn && exists) |=> !exists);

  // R6: a read strobe on an empty mailbox does not create a word.
  p_stray_read_r6: assert property (@(posedge consClk) disable iff (rst)
    (rdEn && !exists) |=> ($past(reqSync) != reqSync) || !exists);

  // R5: a write while full leaves the request toggle untouched.
  p_full_ignore_r5: assert property (@(posedge prodClk) disable iff (rst)
    (wrEn && full) |=> $stable(reqTog));

endmodule

// File: rtl/xclk_mailbox_dpath.sv
module xclk_mailbox_dpath
  import xclk_mailbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              prodClk,
  input  logic              rst,
  input  mbStrobes_t        strobes,
  input  logic              full,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge prodClk or posedge rst) begin
    if (rst) holdReg <= '0;
    else if (strobes.capture) holdReg <= wrData;
  end

  assign rdData = holdReg;

  // R5: the held word does not move while the mailbox is occupied.
  p_hold_stable_r5: assert property (@(posedge prodClk) disable iff (rst)
    full |=> $stable(holdReg));

endmodule

// File: rtl/xclk_mailbox.sv
module xclk_mailbox
  import xclk_mailbox_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              prodClk,
  input  logic              consClk,
  input  logic              mbRst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  input  logic              rdEn,
  output logic              exists,
  output logic [DATA_W-1:0] rdData
);
  mbStrobes_t strobes;

  xclk_mailbox_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .prodClk(prodClk),
    .consClk(consClk),
    .rst    (mbRst),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .full   (full),
    .exists (exists),
    .strobes(strobes)
  );

  xclk_mailbox_dpath #(.DATA_W(DATA_W)) dpath_i (
    .prodClk(prodClk),
    .rst    (mbRst),
    .strobes(strobes),
    .full   (full),
    .wrData (wrData),
    .rdData (rdData)
  );

  // R7: while reset is applied both sides report empty.
  p_reset_empty_r7: assert property (@(posedge prodClk)
    mbRst |-> (!full && !exists));

endmodule

// File: tb/xclk_mailbox_tb_top.sv
`timescale 1ns/10ps
module xclk_mailbox_tb_top;
  localparam int DW     = 16;
  localparam int NWORDS = 40;

  logic          prodClk = 1'b0;
  logic          consClk = 1'b0;
  logic          mbRst   = 1'b1;
  logic          wrEn    = 1'b0;
  logic          rdEn    = 1'b0;
  logic [DW-1:0] wrData  = '0;
  logic          full;
  logic          exists;
  logic [DW-1:0] rdData;

  realtime consHalf = 8.5;
  int checks  = 0;
  int errors  = 0;
  int phase   = 0;
  int written = 0;
  int readCnt = 0;
  int wdog    = 0;

  xclk_mailbox #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .prodClk(prodClk),
    .consClk(consClk),
    .mbRst  (mbRst),
    .wrEn   (wrEn),
    .wrData (wrData),
    .full   (full),
    .rdEn   (rdEn),
    .exists (exists),
    .rdData (rdData)
  );

  always #2.5 prodClk = ~prodClk;
  always #(consHalf) consClk = ~consClk;

  function automatic logic [DW-1:0] wordOf(int ph, int idx);
    return DW'(idx * 40503 + ph * 4099 + 17);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s phase %0d actual=%0d expected=%0d", req, phase, act, exp);
    end
  endtask

  always @(posedge prodClk) begin
    wdog++;
    if (wdog > 150000) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", readCnt, NWORDS);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic doReset();
    wrEn  = 1'b0;
    rdEn  = 1'b0;
    mbRst = 1'b1;
    repeat (3) @(posedge consClk);
    repeat (3) @(posedge prodClk);
    #0.7;
    check("R7 reset full", int'(full), 0);
    check("R7 reset exists", int'(exists), 0);
    mbRst = 1'b0;
    repeat (4) @(posedge consClk);
    repeat (4) @(negedge prodClk);
    check("R7 empty after release full", int'(full), 0);
    check("R7 empty after release exists", int'(exists), 0);
  endtask

  task automatic strayReads();
    for (int i = 0; i < 8; i++) begin
      @(negedge consClk);
      rdEn = 1'b1;
    end
    @(negedge consClk);
    rdEn = 1'b0;
    repeat (3) @(negedge consClk);
    check("R6 stray read exists", int'(exists), 0);
    repeat (4) @(negedge prodClk);
    check("R6 stray read full", int'(full), 0);
  endtask

  task automatic produce();
    int cyc = 0;
    written = 0;
    while (written < NWORDS) begin
      @(negedge prodClk);
      cyc++;
      wrEn = 1'b0;
      if (!full && (cyc % 5) != 0) begin
        wrEn   = 1'b1;
        wrData = wordOf(phase, written);
        @(negedge prodClk);
        wrEn = 1'b0;
        check("R2 full after write", int'(full), 1);
        written++;
      end else if (full && (cyc % 3) == 0) begin
        wrEn   = 1'b1;  // R5: rejected write with corrupt data
        wrData = ~wordOf(phase, written);
      end
    end
    @(negedge prodClk);
    wrEn = 1'b0;
  endtask

  task automatic consume();
    int cyc = 0;
    int waitEdges = 0;
    readCnt = 0;
    while (readCnt < NWORDS) begin
      @(negedge consClk);
      cyc++;
      rdEn = 1'b0;
      if (exists) begin
        if (waitEdges > 0) begin
          check("R3 exists latency bounded", int'(waitEdges <= 4), 1);
          waitEdges = 0;
        end
        if (((cyc + phase) % 3) != 0) begin
          check("R1 R5 R8 word value/order", int'(rdData), int'(wordOf(phase, readCnt)));
          rdEn = 1'b1;
          @(negedge consClk);
          rdEn = 1'b0;
          check("R4 exists drops after read", int'(exists), 0);
          readCnt++;
        end
      end else begin
        if (written > readCnt) waitEdges++;
        rdEn = cyc[0];  // R6: stray read while empty
      end
    end
    @(negedge consClk);
    rdEn = 1'b0;
  endtask

  task automatic midReset();
    @(negedge prodClk);
    wrEn   = 1'b1;
    wrData = 16'h5A5A;
    @(negedge prodClk);
    wrEn = 1'b0;
    while (!exists) @(negedge consClk);
    #1.3;
    mbRst = 1'b1;
    #0.4;
    check("R7 async reset clears exists", int'(exists), 0);
    check("R7 async reset clears full", int'(full), 0);
  endtask

  initial begin
    for (int p = 0; p < 3; p++) begin
      phase    = p;
      consHalf = (p == 0) ? 8.5 : ((p == 1) ? 1.3 : 2.5);
      doReset();
      strayReads();
      fork
        produce();
        consume();
      join
      repeat (8) @(negedge prodClk);
      check("R8 all words read once", readCnt, NWORDS);
      check("R5 no extra word", int'(exists), 0);
      check("R4 full clears after drain", int'(full), 0);
      midReset();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule